// File: doc/BRIEF.md
# Capture/Compare Timer with Handshake-Cleared Status Flags

A 16-bit up-counter advances by one on every clock where the count enable is high. Three general registers, named B, C and D, watch this counter. A mode bit for each register sets its role. In capture mode, a capture strobe stores the counter value in the register. In compare mode, the register is compared against the counter on every counting cycle. Each register has one status flag. The flag is raised by a capture or by a compare match. Software can only lower it through a two-step exchange: it first reads the status register and sees the flag at 1, then writes a 0 to that flag.

Software reaches the counter, the three general registers, the status register and an interrupt-enable register through a simple single-cycle register bus. Reads return data one cycle after the request. Each register has a registered compare-match output. A single interrupt request combines the flags that are enabled.

Top module: `cc_timer_flags`

## Requirements
- R1: After a synchronous reset the counter, the general registers, the flags, the hidden read marks, the interrupt-enable bits, `cmp_out` and `irq` are all 0.
- R2: The counter rises by one on each clock with `cnt_en` high, holds otherwise, wraps from 0xFFFF to 0x0000, and reads at bus address 0.
- R3: With a mode bit at 0 (capture), a high capture strobe stores the counter value held before that clock edge into the register and sets its flag. With the mode bit at 1 the strobe changes neither the register nor the flag.
- R4: With a mode bit at 1 (compare), a clock where `cnt_en` is high and the counter equals the register sets the flag, and the matching `cmp_out` bit is high for the following cycle only. While `cnt_en` is low, an equal value raises nothing.
- R5: Bus addresses are 1, 2 and 3 for registers B, C and D, 4 for status and 5 for interrupt enable. In the status register the flags of D, C and B sit at bits 6, 5 and 4, and every other bit reads 0.
- R6: A flag clears only on a status write carrying 0 in its bit, and only after an earlier status read returned 1 for it. A 0 written without such a read leaves the flag at 1.
- R7: Every status write removes the read mark of every flag, whatever data it carries. A flag that is later written 0 without a fresh read stays set.
- R8: Writing 1 to a status flag bit never sets a flag.
- R9: When a set condition and a valid clearing write land on the same clock, the flag stays at 1.
- R10: `irq` is a register that goes high one cycle after any flag whose enable bit is 1 (enable bits 6, 5 and 4 at address 5 for D, C and B). It stays low when every set flag is disabled.
- R11: `bus_rdata` is registered and shows the addressed value one cycle after `bus_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter enable for this clock |
| cap_strb | input | 3 | Capture strobes, bit 0 = B, 1 = C, 2 = D |
| mode_cmp | input | 3 | Mode per register, 1 = compare, 0 = capture |
| bus_addr | input | 3 | Register bus address |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| cmp_out | output | 3 | Registered compare-match pulses, bit 0 = B |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest cases to reach from the ports are the ordering corners of the clearing exchange. One is a 0 written after a status write has already removed the read mark. The other is a new capture that lands on the same edge as a valid clearing write. The stimulus reaches both through fixed bus sequences. For the same-edge case, it drives a capture strobe and the status write in one cycle and then reads the flag back. The compare match is timed with the counter stopped: the register is loaded two counts ahead, then `cnt_en` is released so the edge where the match occurs is known exactly.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
  localparam int CNT_W    = 16;
  localparam int NUM_CH   = 3;
  localparam int ADDR_W   = 3;
  localparam int STAT_LSB = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CNT  = 3'd0,
    A_GRB  = 3'd1,
    A_GRC  = 3'd2,
    A_GRD  = 3'd3,
    A_STAT = 3'd4,
    A_IEN  = 3'd5
  } ccf_addr_e;
endpackage

// File: rtl/ccf_counter.sv
module ccf_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)     cnt <= '0;
    else if (en) cnt <= cnt + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    en |=> cnt == $past(cnt) + 1'b1); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt)); // R2
endmodule

// File: rtl/ccf_channel.sv
module ccf_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic [W-1:0] cnt,
  input  logic         mode_cmp,
  input  logic         cap,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] gr,
  output logic         hit,
  output logic         cmp_out
);
  logic match;
  logic do_cap;

  assign match  = mode_cmp && cnt_en && (cnt == gr);
  assign do_cap = !mode_cmp && cap;
  assign hit    = match || do_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      gr      <= '0;
      cmp_out <= 1'b0;
    end else begin
      cmp_out <= match;
      if (do_cap)     gr <= cnt;
      else if (wr_en) gr <= wdata;
    end
  end

  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (rst)
    do_cap |=> gr == $past(cnt)); // R3
  AST_CMP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> !cmp_out); // R4
endmodule

// File: rtl/ccf_flag.sv
module ccf_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic rd_stat_i,
  input  logic wr_stat_i,
  input  logic wbit_i,
  output logic flag_q
);
  logic armed_q;
  logic clr_ok;

  assign clr_ok = wr_stat_i && armed_q && !wbit_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (set_i)       flag_q <= 1'b1;
      else if (clr_ok) flag_q <= 1'b0;
      if (wr_stat_i)                 armed_q <= 1'b0;
      else if (rd_stat_i && flag_q)  armed_q <= 1'b1;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_q); // R9
  AST_NO_CLR_UNARMED: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !armed_q) |=> flag_q); // R6
  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !set_i) |=> !flag_q); // R8
  AST_DISARM: assert property (@(posedge clk) disable iff (rst)
    wr_stat_i |=> !armed_q); // R7
endmodule

// File: rtl/cc_timer_flags.sv
module cc_timer_flags
  import ccf_pkg::*;
#(
  parameter int CW  = ccf_pkg::CNT_W,
  parameter int NCH = ccf_pkg::NUM_CH,
  parameter int SLB = ccf_pkg::STAT_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic [NCH-1:0]    cap_strb,
  input  logic [NCH-1:0]    mode_cmp,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [CW-1:0]     bus_wdata,
  output logic [CW-1:0]     bus_rdata,
  output logic [NCH-1:0]    cmp_out,
  output logic              irq
);
  localparam int SHI = SLB + NCH - 1;

  logic [CW-1:0]  cnt;
  logic [CW-1:0]  gr [NCH];
  logic [NCH-1:0] hit;
  logic [NCH-1:0] flags;
  logic [NCH-1:0] ien;
  logic [CW-1:0]  rd_mux;
  logic           rd_stat, wr_stat, wr_ien;

  assign rd_stat = bus_rd && (bus_addr == A_STAT);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_ien  = bus_wr && (bus_addr == A_IEN);

  ccf_counter #(.W(CW)) u_cnt (
    .clk(clk), .rst(rst), .en(cnt_en), .cnt(cnt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] GR_ADDR = ADDR_W'(int'(A_GRB) + g);
    logic gr_wr;
    assign gr_wr = bus_wr && (bus_addr == GR_ADDR);

    ccf_channel #(.W(CW)) u_ch (
      .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt(cnt),
      .mode_cmp(mode_cmp[g]), .cap(cap_strb[g]),
      .wr_en(gr_wr), .wdata(bus_wdata),
      .gr(gr[g]), .hit(hit[g]), .cmp_out(cmp_out[g])
    );

    ccf_flag u_flag (
      .clk(clk), .rst(rst), .set_i(hit[g]),
      .rd_stat_i(rd_stat), .wr_stat_i(wr_stat),
      .wbit_i(bus_wdata[SLB+g]), .flag_q(flags[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CNT:   rd_mux = cnt;
      A_STAT:  rd_mux[SHI:SLB] = flags;
      A_IEN:   rd_mux[SHI:SLB] = ien;
      default: begin
        for (int i = 0; i < NCH; i++)
          if (bus_addr == ADDR_W'(int'(A_GRB) + i)) rd_mux = gr[i];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien       <= '0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (wr_ien) ien <= bus_wdata[SHI:SLB];
      irq <= |(flags & ien);
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (|(flags & ien)) |=> irq); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    ((flags & ien) == '0) |=> !irq); // R10
endmodule

// File: tb/test_cc_timer_flags.sv
module test_cc_timer_flags;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } rd_item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic [2:0]  cap_strb = '0;
  logic [2:0]  mode_cmp = '0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [2:0]  cmp_out;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  rd_item_t exp_q[$];
  logic rd_d = 1'b0;
  logic [15:0] mcnt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_timer_flags i_cc_timer_flags (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .cap_strb(cap_strb),
    .mode_cmp(mode_cmp), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_out(cmp_out), .irq(irq)
  );

  // counter model from R2
  always @(posedge clk) begin
    if (rst)         mcnt <= '0;
    else if (cnt_en) mcnt <= mcnt + 16'd1;
    rd_d <= bus_rd;
  end

  // monitor: read data appears one cycle after the request (R11)
  always @(negedge clk) begin
    if (rd_d) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R11 unexpected read data: actual %h expected none", bus_rdata);
      end else begin
        rd_item_t it;
        it = exp_q.pop_front();
        if (bus_rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic bus_read(input logic [2:0] a, input logic [15:0] e, input string tag);
    rd_item_t it;
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse_cap(input int ch);
    cap_strb[ch] = 1'b1;
    @(negedge clk);
    cap_strb = '0;
  endtask

  task automatic run_cnt(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic check(input logic [15:0] act, input logic [15:0] e, input string tag);
    n_tests++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (R1..): actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] cap_c, cap_d, gv;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check({13'd0, cmp_out}, 16'h0, "R1 cmp_out after reset");
    check({15'd0, irq}, 16'h0, "R1 irq after reset");
    bus_read(3'd0, 16'h0000, "R1 counter after reset");
    bus_read(3'd4, 16'h0000, "R1 status after reset");
    bus_read(3'd1, 16'h0000, "R1 GR B after reset");

    // R2 counting
    run_cnt(7);
    bus_read(3'd0, mcnt, "R2 counter after 7 enabled cycles");
    repeat (2) @(negedge clk);
    bus_read(3'd0, mcnt, "R2 counter holds with enable low");

    // R3 capture on C, R6 unarmed write 0 ignored
    cap_c = mcnt;
    pulse_cap(1);
    bus_write(3'd4, 16'h0000);
    bus_read(3'd4, 16'h0020, "R6 unarmed write 0 keeps flag C (R5 bit5)");
    bus_write(3'd4, 16'h0000);
    bus_read(3'd4, 16'h0000, "R6 read-then-write0 clears flag C");
    bus_read(3'd2, cap_c, "R3 GR C holds captured count");

    // R8 writing ones does not set
    bus_write(3'd4, 16'hFFFF);
    bus_read(3'd4, 16'h0000, "R8 write of ones sets no flag");

    // R7 any status write disarms
    pulse_cap(0);
    bus_read(3'd4, 16'h0010, "R5 flag B at bit4");
    bus_write(3'd4, 16'h0010);
    bus_write(3'd4, 16'h0000);
    bus_read(3'd4, 16'h0010, "R7 disarmed flag B survives write 0");
    bus_write(3'd4, 16'h0000);
    bus_read(3'd4, 16'h0000, "R6 flag B cleared after fresh read");

    // R9 set wins over clear
    run_cnt(3);
    pulse_cap(2);
    bus_read(3'd4, 16'h0040, "R5 flag D at bit6");
    cap_d = mcnt;
    cap_strb[2] = 1'b1;
    bus_write(3'd4, 16'h0000);
    cap_strb = '0;
    bus_read(3'd4, 16'h0040, "R9 set and clear same cycle keeps flag D");
    bus_read(3'd3, cap_d, "R3 GR D recaptured");
    bus_read(3'd4, 16'h0040, "R9 arm D");
    bus_write(3'd4, 16'h0000);
    bus_read(3'd4, 16'h0000, "R6 flag D cleared");

    // R3 strobe ignored in compare mode
    mode_cmp = 3'b010;
    pulse_cap(1);
    bus_read(3'd2, cap_c, "R3 compare-mode GR C ignores strobe");
    bus_read(3'd4, 16'h0000, "R3 compare-mode strobe sets no flag");
    mode_cmp = 3'b000;

    // R4 no match while counter disabled
    mode_cmp = 3'b001;
    bus_write(3'd1, mcnt);
    repeat (3) begin
      @(negedge clk);
      check({13'd0, cmp_out}, 16'h0, "R4 no cmp_out with cnt_en low");
    end
    bus_read(3'd4, 16'h0000, "R4 no flag with cnt_en low");

    // R4 match and R10 irq
    bus_write(3'd5, 16'h0010);
    gv = mcnt + 16'd2;
    bus_write(3'd1, gv);
    cnt_en = 1'b1;
    repeat (3) @(negedge clk);
    check({13'd0, cmp_out}, 16'h0001, "R4 cmp_out B pulses at match");
    check({15'd0, irq}, 16'h0, "R10 irq not yet (registered)");
    @(negedge clk);
    cnt_en = 1'b0;
    check({13'd0, cmp_out}, 16'h0000, "R4 cmp_out B one cycle only");
    check({15'd0, irq}, 16'h1, "R10 irq raised by enabled flag B");
    mode_cmp = 3'b000;
    bus_read(3'd4, 16'h0010, "R4 compare sets flag B");
    bus_write(3'd4, 16'h0000);
    @(negedge clk);
    check({15'd0, irq}, 16'h0, "R10 irq drops after clear");

    // R10 gating
    bus_write(3'd5, 16'h0000);
    pulse_cap(1);
    repeat (2) @(negedge clk);
    check({15'd0, irq}, 16'h0, "R10 disabled flag C gives no irq");
    bus_write(3'd5, 16'h0020);
    @(negedge clk);
    check({15'd0, irq}, 16'h1, "R10 enabling C raises irq");
    bus_read(3'd5, 16'h0020, "R5 enable register readback");
    bus_read(3'd4, 16'h0020, "R10 arm C");
    bus_write(3'd4, 16'h0000);
    bus_write(3'd5, 16'h0000);

    // R2 wrap
    begin
      int n;
      n = 65536 - int'(mcnt);
      run_cnt(n);
    end
    bus_read(3'd0, 16'h0000, "R2 counter wraps to zero");
    bus_read(3'd4, 16'h0000, "R6 no flags left");

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule